// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port

This block is the host-facing register front end of a real-time clock. A two-location port reaches a 128-byte space: a write to the even location picks a byte index, and an access to the odd location reads or writes the byte at that index. Most of the space is plain battery-backed style RAM. A few indices hold the clock's control and flag registers, and these have their own access rules. Register A carries a read-only update-busy bit and a divider field. Register B holds the interrupt enables and a freeze bit. Register C collects interrupt flags and is cleared by reading it. Register D is constant.

The block also runs the once-per-second update cycle. It starts the cycle on a one-second tick, holds the busy bit for a fixed number of sub-second ticks, and at the end of the cycle compares three alarm bytes against the current time and raises the update-ended and alarm flags. A flag strobe from the external rate generator sets the periodic flag. The calendar counters and the rate divider sit outside the block. They get the update start pulse and return the current seconds, minutes and hours bytes. The interrupt output is a level that drops only when register C is read or the flags are cleared.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even location (acc_addr=0) loads data bits 6:0 as the index and ignores bit 7. A read of the even location returns 0xFF.
- R2: A write to the odd location stores the byte at the current index. A later read of the odd location with the same index returns it, for every general index (14 to 127).
- R3: After rst_n the control registers read A=0x26, B=0x02, C=0x00 and D=0x80, and irq_o is low.
- R4: Writes to index 12 (C) and index 13 (D) have no effect. C keeps its value and D always reads 0x80.
- R5: A write to index 10 (A) replaces bits 6:0 and leaves bit 7 (update busy) as it was.
- R6: A write to index 11 (B) with bit 7 (freeze) set stores bit 4 (update-ended enable) as 0 and clears bit 7 of A.
- R7: A read of index 12 returns the current C value and then clears C, which drops irq_o. Flags raised in the same cycle as the read are kept.
- R8: A soft_clr pulse clears B bits 6, 5 and 3 and C bits 7 to 4, and leaves the other bits of B as they were.
- R9: The update cycle starts on sec_tick only when A bits 6:4 equal 3'b010. upd_start_o pulses in that cycle. With any other divider value, sec_tick has no effect.
- R10: At update start, A bit 7 is set unless B bit 7 is set. Bit 7 clears on the UPD_TICKS-th sub_tick pulse after the start.
- R11: At update end, C bit 4 is set. C bit 7 is set, and irq_o rises, only when B bit 4 is set.
- R12: At update end with B bit 5 set, C bits 7 and 5 are set when each alarm byte (indices 1, 3, 5) either has bits 7:6 equal to 11 or equals cur_sec, cur_min and cur_hour respectively.
- R13: pf_strobe with B bit 6 set sets C bits 7 and 6. With B bit 6 clear it is ignored.
- R14: irq_o follows C bit 7. Once high it stays high until C is read or soft_clr is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to power-up values |
| soft_clr | input | 1 | Clears the enable and flag bits (R8) |
| acc_en | input | 1 | Host access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index location, 1 = data location |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| sec_tick | input | 1 | One-second strobe that starts an update |
| sub_tick | input | 1 | Sub-second strobe that times the busy window |
| pf_strobe | input | 1 | Periodic flag strobe from the rate generator |
| cur_sec | input | 8 | Current seconds byte from the calendar |
| cur_min | input | 8 | Current minutes byte from the calendar |
| cur_hour | input | 8 | Current hours byte from the calendar |
| upd_start_o | output | 1 | Update start pulse to the calendar |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps all 27 combinations of exact, mismatching and don't-care alarm bytes. An alarm comparator that used the wrong byte, or treated a single high bit as don't-care, would flag on a mismatch. It also sweeps all eight divider values, so an update that ran on the wrong divider would set the update-ended flag when it should stay quiet. A C read is made in the same cycle as a periodic strobe, and a design that let the clear win would lose that interrupt. The bench also checks that a freeze write removes the update-ended enable and the busy bit, and that a write to A cannot forge or erase the busy bit.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  // register indices (host software decodes these)
  localparam int IX_ALM_S = 1;
  localparam int IX_ALM_M = 3;
  localparam int IX_ALM_H = 5;
  localparam int IX_A     = 10;
  localparam int IX_B     = 11;
  localparam int IX_C     = 12;
  localparam int IX_D     = 13;

  // bit positions
  localparam int A_BUSY   = 7;
  localparam int B_FRZ    = 7;
  localparam int B_PER_EN = 6;
  localparam int B_ALM_EN = 5;
  localparam int B_UPD_EN = 4;
  localparam int C_ANY    = 7;
  localparam int C_PER    = 6;
  localparam int C_ALM    = 5;
  localparam int C_UPD    = 4;

  localparam logic [7:0] A_RST      = 8'h26;
  localparam logic [7:0] B_RST      = 8'h02;
  localparam logic [7:0] C_RST      = 8'h00;
  localparam logic [7:0] D_VAL      = 8'h80;
  localparam logic [2:0] DIV_RUN    = 3'b010;
  localparam logic [7:0] B_SOFT_CLR = 8'h68;
  localparam logic [7:0] C_SOFT_CLR = 8'hF0;
endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N-1:0][W-1:0] alm,
  input  logic [N-1:0][W-1:0] cur,
  output logic                hit
);
  logic [N-1:0] fld_ok;

  for (genvar i = 0; i < N; i++) begin : g_fld
    // top two bits both set marks the field as a wildcard
    assign fld_ok[i] = (&alm[i][W-1:W-2]) | (alm[i] == cur[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic sub_tick,
  input  logic run_ok,
  output logic start_p,
  output logic end_p
);
  localparam int CW = $clog2(TICKS + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  assign start_p = sec_tick & run_ok & ~busy;
  assign end_p   = busy & sub_tick & (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_p) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (end_p) begin
      busy <= 1'b0;
    end else if (busy && sub_tick) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int UPD_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic       acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       sec_tick,
  input  logic       sub_tick,
  input  logic       pf_strobe,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  output logic       upd_start_o,
  output logic       irq_o
);
  localparam int ALM_N = 3;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       reg_a, reg_b, reg_c;
  logic [7:0]       a_nxt, b_nxt, c_nxt, c_set;
  logic [7:0]       alm_s, alm_m, alm_h;
  logic [7:0]       ram_q;
  logic             upd_start, upd_end, alm_hit;
  logic             b_frz_nxt;

  wire idx_wr  = acc_en &  acc_wr & ~acc_addr;
  wire data_wr = acc_en &  acc_wr &  acc_addr;
  wire data_rd = acc_en & ~acc_wr &  acc_addr;

  wire sel_a  = (idx_q == IDX_W'(IX_A));
  wire sel_b  = (idx_q == IDX_W'(IX_B));
  wire sel_c  = (idx_q == IDX_W'(IX_C));
  wire sel_d  = (idx_q == IDX_W'(IX_D));
  wire sel_as = (idx_q == IDX_W'(IX_ALM_S));
  wire sel_am = (idx_q == IDX_W'(IX_ALM_M));
  wire sel_ah = (idx_q == IDX_W'(IX_ALM_H));

  wire b_wr = data_wr & sel_b;
  wire c_rd = data_rd & sel_c;

  // index register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= acc_wdata[IDX_W-1:0];
  end

  // general byte storage
  rtc_ram #(.AW(IDX_W), .DW(8)) u_ram (
    .clk   (clk),
    .we    (data_wr),
    .addr  (idx_q),
    .wdata (acc_wdata),
    .rdata (ram_q)
  );

  // update cycle timing
  rtc_upd_seq #(.TICKS(UPD_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .sub_tick (sub_tick),
    .run_ok   (reg_a[6:4] == DIV_RUN),
    .start_p  (upd_start),
    .end_p    (upd_end)
  );

  // alarm comparison
  rtc_alarm_match #(.N(ALM_N), .W(8)) u_alm (
    .alm ({alm_h, alm_m, alm_s}),
    .cur ({cur_hour, cur_min, cur_sec}),
    .hit (alm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_s <= '0;
      alm_m <= '0;
      alm_h <= '0;
    end else if (data_wr) begin
      if (sel_as) alm_s <= acc_wdata;
      if (sel_am) alm_m <= acc_wdata;
      if (sel_ah) alm_h <= acc_wdata;
    end
  end

  // register B
  assign b_frz_nxt = b_wr ? acc_wdata[B_FRZ] : reg_b[B_FRZ];

  always_comb begin
    b_nxt = reg_b;
    if (b_wr) begin
      b_nxt = acc_wdata;
      if (acc_wdata[B_FRZ]) b_nxt[B_UPD_EN] = 1'b0;
    end
    if (soft_clr) b_nxt = b_nxt & ~B_SOFT_CLR;
  end

  // register A
  always_comb begin
    a_nxt = reg_a;
    if (data_wr && sel_a) a_nxt[6:0] = acc_wdata[6:0];
    if (upd_start && !b_frz_nxt) a_nxt[A_BUSY] = 1'b1;
    if (upd_end) a_nxt[A_BUSY] = 1'b0;
    if (b_wr && acc_wdata[B_FRZ]) a_nxt[A_BUSY] = 1'b0;
  end

  // register C
  always_comb begin
    c_set = '0;
    if (upd_end) begin
      c_set[C_UPD] = 1'b1;
      if (reg_b[B_UPD_EN]) c_set[C_ANY] = 1'b1;
      if (reg_b[B_ALM_EN] && alm_hit) begin
        c_set[C_ANY] = 1'b1;
        c_set[C_ALM] = 1'b1;
      end
    end
    if (pf_strobe && reg_b[B_PER_EN]) begin
      c_set[C_ANY] = 1'b1;
      c_set[C_PER] = 1'b1;
    end
    c_nxt = (c_rd ? 8'h00 : reg_c) | c_set;
    if (soft_clr) c_nxt = c_nxt & ~C_SOFT_CLR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= A_RST;
      reg_b <= B_RST;
      reg_c <= C_RST;
    end else begin
      reg_a <= a_nxt;
      reg_b <= b_nxt;
      reg_c <= c_nxt;
    end
  end

  // read path
  always_comb begin
    if (!acc_addr)   acc_rdata = 8'hFF;
    else if (sel_a)  acc_rdata = reg_a;
    else if (sel_b)  acc_rdata = reg_b;
    else if (sel_c)  acc_rdata = reg_c;
    else if (sel_d)  acc_rdata = D_VAL;
    else if (sel_as) acc_rdata = alm_s;
    else if (sel_am) acc_rdata = alm_m;
    else if (sel_ah) acc_rdata = alm_h;
    else             acc_rdata = ram_q;
  end

  assign irq_o       = reg_c[C_ANY];
  assign upd_start_o = upd_start;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             acc_en,
  input logic             acc_wr,
  input logic             acc_addr,
  input logic [7:0]       acc_wdata,
  input logic [7:0]       acc_rdata,
  input logic             sub_tick,
  input logic             pf_strobe,
  input logic             upd_start_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       reg_a,
  input logic [7:0]       reg_b,
  input logic [7:0]       reg_c,
  input logic             upd_end
);
  wire rd_odd = acc_en & ~acc_wr & acc_addr;
  wire wr_odd = acc_en &  acc_wr & acc_addr;

  AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_addr) |-> acc_rdata == 8'hFF); // R1

  AST_D_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && idx_q == IDX_W'(13)) |-> acc_rdata == 8'h80); // R4

  AST_A_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd && idx_q == IDX_W'(10) && !upd_end && !upd_start_o) |=> reg_a[7] == $past(reg_a[7])); // R5

  AST_FREEZE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd && idx_q == IDX_W'(11) && acc_wdata[7]) |=> (!reg_a[7] && !reg_b[4])); // R6

  AST_C_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && idx_q == IDX_W'(12) && !pf_strobe && !sub_tick) |=> (reg_c == 8'h00 && !irq_o)); // R7

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ((reg_b & 8'h68) == 8'h00 && reg_c[7:4] == 4'h0)); // R8

  AST_START_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    upd_start_o |-> reg_a[6:4] == 3'b010); // R9

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(rd_odd && idx_q == IDX_W'(12)) && !soft_clr) |=> irq_o); // R14
endmodule

bind rtc_regport rtc_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_clr    (soft_clr),
  .acc_en      (acc_en),
  .acc_wr      (acc_wr),
  .acc_addr    (acc_addr),
  .acc_wdata   (acc_wdata),
  .acc_rdata   (acc_rdata),
  .sub_tick    (sub_tick),
  .pf_strobe   (pf_strobe),
  .upd_start_o (upd_start_o),
  .irq_o       (irq_o),
  .idx_q       (idx_q),
  .reg_a       (reg_a),
  .reg_b       (reg_b),
  .reg_c       (reg_c),
  .upd_end     (upd_end)
);

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
  localparam int UPD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_clr = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0, acc_addr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       sec_tick = 1'b0, sub_tick = 1'b0, pf_strobe = 1'b0;
  logic [7:0] cur_sec = 8'h30, cur_min = 8'h15, cur_hour = 8'h08;
  logic       upd_start_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rtc_regport #(.IDX_W(7), .UPD_TICKS(UPD)) uut (
    .clk, .rst_n, .soft_clr, .acc_en, .acc_wr, .acc_addr, .acc_wdata,
    .acc_rdata, .sec_tick, .sub_tick, .pf_strobe, .cur_sec, .cur_min,
    .cur_hour, .upd_start_o, .irq_o
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(bit a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wreg(logic [7:0] ix, logic [7:0] d);
    wr(1'b0, ix);
    wr(1'b1, d);
  endtask

  task automatic rreg(logic [7:0] ix, output logic [7:0] d);
    wr(1'b0, ix);
    rd(1'b1, d);
  endtask

  task automatic pulse_sec(output logic started);
    @(negedge clk);
    sec_tick = 1'b1;
    #1 started = upd_start_o;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic subs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  task automatic pf_pulse();
    @(negedge clk); pf_strobe = 1'b1;
    @(negedge clk); pf_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       st;
    logic [7:0] as, am, ah;
    bit         hit;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    rreg(8'd10, d); chk("R3 A", d, 8'h26);
    rreg(8'd11, d); chk("R3 B", d, 8'h02);
    rreg(8'd12, d); chk("R3 C", d, 8'h00);
    rreg(8'd13, d); chk("R3 D", d, 8'h80);
    chk("R3 irq", {7'b0, irq_o}, 8'h00);

    // R1 even location
    rd(1'b0, d); chk("R1 even read", d, 8'hFF);
    wreg(8'h8E, 8'h33);             // bit 7 dropped: index 14
    rreg(8'h0E, d); chk("R1 index bit7 ignored", d, 8'h33);

    // R2 sweep of general bytes
    for (int i = 14; i < 128; i++) wreg(8'(i), 8'(i) ^ 8'h5A);
    for (int i = 14; i < 128; i++) begin
      rreg(8'(i), d); chk("R2 ram", d, 8'(i) ^ 8'h5A);
    end

    // R4 C and D not writable
    wreg(8'd12, 8'hFF); rreg(8'd12, d); chk("R4 C write", d, 8'h00);
    chk("R4 irq", {7'b0, irq_o}, 8'h00);
    wreg(8'd13, 8'h00); rreg(8'd13, d); chk("R4 D write", d, 8'h80);

    // R10 / R5 busy bit through an update
    pulse_sec(st); chk("R9 start seen", {7'b0, st}, 8'h01);
    rreg(8'd10, d); chk("R10 busy set", d, 8'hA6);
    wreg(8'd10, 8'h25); rreg(8'd10, d); chk("R5 busy kept", d, 8'hA5);
    wreg(8'd10, 8'h26);
    subs(UPD - 1);
    rreg(8'd10, d); chk("R10 busy before end", d, 8'hA6);
    subs(1);
    rreg(8'd10, d); chk("R10 busy cleared", d, 8'h26);
    chk("R11 no irq without enable", {7'b0, irq_o}, 8'h00);
    rreg(8'd12, d); chk("R11 flag only", d, 8'h10);
    rreg(8'd12, d); chk("R7 cleared", d, 8'h00);

    // R11 / R14 / R7 with update-ended enable
    wreg(8'd11, 8'h12);
    pulse_sec(st); subs(UPD);
    chk("R11 irq raised", {7'b0, irq_o}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R14 irq holds", {7'b0, irq_o}, 8'h01);
    rreg(8'd12, d); chk("R7 read value", d, 8'h90);
    chk("R7 irq dropped", {7'b0, irq_o}, 8'h00);

    // R6 freeze
    pulse_sec(st);
    wreg(8'd11, 8'h92);
    rreg(8'd11, d); chk("R6 enable forced off", d, 8'h82);
    rreg(8'd10, d); chk("R6 busy cleared", d, 8'h26);
    subs(UPD);
    rreg(8'd12, d);
    pulse_sec(st);
    rreg(8'd10, d); chk("R10 no busy in freeze", d, 8'h26);
    subs(UPD);
    rreg(8'd12, d); chk("R11 flag in freeze", d, 8'h10);
    wreg(8'd11, 8'h02);

    // R9 divider sweep
    for (int dv = 0; dv < 8; dv++) begin
      wreg(8'd10, {1'b0, 3'(dv), 4'h6});
      pulse_sec(st);
      chk("R9 start", {7'b0, st}, (dv == 2) ? 8'h01 : 8'h00);
      subs(UPD);
      rreg(8'd12, d);
      chk("R9 flag", d, (dv == 2) ? 8'h10 : 8'h00);
    end
    wreg(8'd10, 8'h26);

    // R13 periodic strobe
    pf_pulse();
    rreg(8'd12, d); chk("R13 ignored", d, 8'h00);
    wreg(8'd11, 8'h42);
    pf_pulse();
    chk("R13 irq", {7'b0, irq_o}, 8'h01);
    rreg(8'd12, d); chk("R13 flags", d, 8'hC0);

    // R7 strobe in the read cycle is kept
    wr(1'b0, 8'd12);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 1'b1; pf_strobe = 1'b1;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0; pf_strobe = 1'b0;
    chk("R7 old value", d, 8'h00);
    chk("R7 new flag kept irq", {7'b0, irq_o}, 8'h01);
    rd(1'b1, d); chk("R7 new flag kept", d, 8'hC0);

    // R8 soft clear
    wreg(8'd11, 8'h7E);
    pf_pulse();
    chk("R14 irq before clear", {7'b0, irq_o}, 8'h01);
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
    chk("R8 irq", {7'b0, irq_o}, 8'h00);
    rreg(8'd11, d); chk("R8 B", d, 8'h16);
    rreg(8'd12, d); chk("R8 C", d, 8'h00);

    // R12 alarm sweep: exact, off by one, wildcard per field
    wreg(8'd11, 8'h22);
    for (int k = 0; k < 27; k++) begin
      int ds, dm, dh;
      ds = k % 3; dm = (k / 3) % 3; dh = k / 9;
      as = (ds == 0) ? cur_sec  : (ds == 1) ? (cur_sec  ^ 8'h01) : (8'hC0 | 8'(k));
      am = (dm == 0) ? cur_min  : (dm == 1) ? (cur_min  ^ 8'h01) : (8'hC0 | 8'(k));
      ah = (dh == 0) ? cur_hour : (dh == 1) ? (cur_hour ^ 8'h01) : (8'hC0 | 8'(k));
      hit = (ds != 1) && (dm != 1) && (dh != 1);
      wreg(8'd1, as); wreg(8'd3, am); wreg(8'd5, ah);
      pulse_sec(st); subs(UPD);
      chk("R12 irq", {7'b0, irq_o}, hit ? 8'h01 : 8'h00);
      rreg(8'd12, d);
      chk("R12 flags", d, hit ? 8'hB0 : 8'h10);
    end
    // a single high bit is not a wildcard
    wreg(8'd1, 8'hB0); wreg(8'd3, cur_min); wreg(8'd5, cur_hour);
    pulse_sec(st); subs(UPD);
    rreg(8'd12, d); chk("R12 one high bit", d, 8'h10);
    // match with alarm enable off
    wreg(8'd1, cur_sec); wreg(8'd11, 8'h02);
    pulse_sec(st); subs(UPD);
    rreg(8'd12, d); chk("R12 enable off", d, 8'h10);
    rreg(8'd1, d); chk("R12 alarm byte readback", d, cur_sec);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule